// File: doc/BRIEF.md
# Interrupt Shadow Controller

This block decides, at every instruction boundary of a small 16-bit processor, whether a pending interrupt may be taken. A boundary is marked by a one-cycle retire strobe, which comes with a small class code for the instruction that just finished. A decode table built from those codes picks out the instructions that write a segment register. Moving or popping into the stack segment must be followed by a separate load of the stack pointer. If an interrupt landed between the two loads, it would push its context to a wrong address. A retire of such a trigger instruction therefore opens a shadow of one instruction. At that boundary no interrupt is recognised, the non-maskable one included. At the next boundary interrupts are allowed again.

A mode input sets how wide the trigger is. In narrow mode only stack-segment loads trigger the shadow. In broad mode a load into any segment register triggers it. Requests that arrive during the shadow are held and are taken at the first open boundary. The non-maskable request wins over the maskable one. The maskable request is gated by the interrupt-enable flag. The result is a one-cycle acknowledge pulse together with a vector-select bit.

Top module: `irq_shadow_unit`

## Requirements
- R1: While reset is asserted and after it is released, `ackValid` and `shadowActive` are 0 until a retire strobe says otherwise.
- R2: A retire of class 1 (move into stack segment) or class 2 (pop into stack segment) gives no acknowledge at that boundary, and `shadowActive` is 1 from the next cycle on.
- R3: While the shadow is active, a retire of a non-trigger class clears `shadowActive`, and an interrupt may be acknowledged at that same boundary.
- R4: A trigger class retiring while the shadow is active re-arms it for one more instruction, again with no acknowledge.
- R5: The shadow holds off the non-maskable request as well as the maskable one.
- R6: With `segMode`=1, classes 1 to 4 are triggers (3 = move into another segment register, 4 = pop into another segment register). With `segMode`=0 only classes 1 and 2 are triggers, and classes 3 and 4 behave like ordinary instructions.
- R7: If both requests are pending at an open boundary, the non-maskable one is acknowledged (`ackNmi`=1) and the maskable one waits for a later boundary.
- R8: The maskable request is acknowledged only while `intEnable`=1. The non-maskable request is acknowledged whatever `intEnable` is.
- R9: Requests are not lost during a shadow. A maskable request held high is taken at the first open boundary. A rising edge on `nmiReq` is latched until it is acknowledged, even if the line falls first.
- R10: `ackValid` is high for exactly the one cycle after the clock edge that sampled an accepting retire strobe, and never without a retire. `ackNmi`=1 selects the non-maskable vector and 0 the maskable one.
- R11: In cycles with no retire strobe, `shadowActive` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retireValid | input | 1 | One-cycle strobe marking an instruction boundary |
| retireClass | input | 3 | Decode class of the retiring instruction |
| segMode | input | 1 | 1 = any segment load triggers the shadow, 0 = stack segment loads only |
| intEnable | input | 1 | Interrupt-enable flag for the maskable request |
| intrReq | input | 1 | Maskable request, level |
| nmiReq | input | 1 | Non-maskable request, rising edge latched |
| ackValid | output | 1 | Acknowledge pulse |
| ackNmi | output | 1 | Vector select during `ackValid`: 1 non-maskable, 0 maskable |
| shadowActive | output | 1 | The next instruction boundary is protected |

## Verification
The main function is tried with back-to-back stack-segment loads, single loads followed by an ordinary instruction, and loads of other segment registers in both modes. Together these separate a one-boundary shadow from a longer one and show re-arming. They also show that the mode, and not the class alone, chooses the trigger set. Both request types are raised before a shadow opens and then released during it. Taking them at the first open boundary, and not earlier, shows that the shadow blocks the non-maskable request too and that the latched edge survives. Concurrent requests, and a cleared enable flag, separate the priority order from the masking rule.

// File: rtl/irq_shadow_pkg.sv
package irq_shadow_pkg;

  localparam int CLASS_W = 3;
  localparam int NUM_CLASS = 1 << CLASS_W;

  typedef enum logic [CLASS_W-1:0] {
    CLS_PLAIN   = 3'd0,
    CLS_MOV_SS  = 3'd1,
    CLS_POP_SS  = 3'd2,
    CLS_MOV_SEG = 3'd3,
    CLS_POP_SEG = 3'd4,
    CLS_BRANCH  = 3'd5,
    CLS_STRING  = 3'd6,
    CLS_HALT    = 3'd7
  } instr_class_e;

  typedef struct packed {
    logic armShadow;
    logic dropShadow;
    logic takeNmi;
    logic takeIntr;
  } ctrl_strobe_t;

  // decode-table product terms: one entry per class code
  function automatic logic writesStackSeg(input logic [CLASS_W-1:0] code);
    return (code == CLS_MOV_SS) || (code == CLS_POP_SS);
  endfunction

  function automatic logic writesAnySeg(input logic [CLASS_W-1:0] code);
    return writesStackSeg(code) || (code == CLS_MOV_SEG) || (code == CLS_POP_SEG);
  endfunction

endpackage

// File: rtl/irq_shadow_ctrl.sv
module irq_shadow_ctrl
  import irq_shadow_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               retireValid,
  input  logic [CLASS_W-1:0] retireClass,
  input  logic               segMode,
  input  logic               intEnable,
  input  logic               intrReq,
  input  logic               nmiAvail,
  output ctrl_strobe_t       strobes
);

  logic [NUM_CLASS-1:0] stackSegTbl;
  logic [NUM_CLASS-1:0] anySegTbl;

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_tbl
    assign stackSegTbl[c] = writesStackSeg(CLASS_W'(c));
    assign anySegTbl[c]   = writesAnySeg(CLASS_W'(c));
  end

  logic isTrigger;
  logic openBoundary;

  always_comb begin
    isTrigger    = segMode ? anySegTbl[retireClass] : stackSegTbl[retireClass];
    openBoundary = retireValid && !isTrigger;
    strobes.armShadow  = retireValid && isTrigger;
    strobes.dropShadow = openBoundary;
    strobes.takeNmi    = openBoundary && nmiAvail;
    strobes.takeIntr   = openBoundary && !nmiAvail && intrReq && intEnable;
  end

  AST_TAKE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({strobes.armShadow, strobes.takeNmi, strobes.takeIntr}) <= 1); // R7

  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (nmiAvail && strobes.takeIntr) |-> 1'b0); // R7

endmodule

// File: rtl/irq_shadow_dp.sv
module irq_shadow_dp
  import irq_shadow_pkg::*;
#(
  parameter bit NMI_EDGE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         nmiReq,
  input  ctrl_strobe_t strobes,
  output logic         nmiAvail,
  output logic         shadowQ,
  output logic         ackValidQ,
  output logic         ackNmiQ
);

  if (NMI_EDGE) begin : g_edge
    logic nmiReqQ;
    logic nmiPendQ;
    assign nmiAvail = nmiPendQ || (nmiReq && !nmiReqQ);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        nmiReqQ  <= 1'b0;
        nmiPendQ <= 1'b0;
      end else begin
        nmiReqQ  <= nmiReq;
        nmiPendQ <= nmiAvail && !strobes.takeNmi;
      end
    end

    AST_NMI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (nmiAvail && !strobes.takeNmi) |=> nmiAvail); // R9
  end else begin : g_level
    assign nmiAvail = nmiReq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadowQ   <= 1'b0;
      ackValidQ <= 1'b0;
      ackNmiQ   <= 1'b0;
    end else begin
      if (strobes.armShadow)       shadowQ <= 1'b1;
      else if (strobes.dropShadow) shadowQ <= 1'b0;
      ackValidQ <= strobes.takeNmi || strobes.takeIntr;
      ackNmiQ   <= strobes.takeNmi;
    end
  end

  AST_ARM_BLOCKS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.armShadow |=> (shadowQ && !ackValidQ)); // R2

endmodule

// File: rtl/irq_shadow_unit.sv
module irq_shadow_unit
  import irq_shadow_pkg::*;
#(
  parameter bit NMI_EDGE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               retireValid,
  input  logic [CLASS_W-1:0] retireClass,
  input  logic               segMode,
  input  logic               intEnable,
  input  logic               intrReq,
  input  logic               nmiReq,
  output logic               ackValid,
  output logic               ackNmi,
  output logic               shadowActive
);

  ctrl_strobe_t strobes;
  logic nmiAvail;

  irq_shadow_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .retireValid (retireValid),
    .retireClass (retireClass),
    .segMode     (segMode),
    .intEnable   (intEnable),
    .intrReq     (intrReq),
    .nmiAvail    (nmiAvail),
    .strobes     (strobes)
  );

  irq_shadow_dp #(.NMI_EDGE(NMI_EDGE)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmiReq    (nmiReq),
    .strobes   (strobes),
    .nmiAvail  (nmiAvail),
    .shadowQ   (shadowActive),
    .ackValidQ (ackValid),
    .ackNmiQ   (ackNmi)
  );

  logic ssClass;
  logic otherSegClass;
  assign ssClass       = (retireClass == CLS_MOV_SS) || (retireClass == CLS_POP_SS);
  assign otherSegClass = (retireClass == CLS_MOV_SEG) || (retireClass == CLS_POP_SEG);

  AST_SS_LOAD_SHADOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (retireValid && ssClass) |=> (shadowActive && !ackValid)); // R2

  AST_SHADOW_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (retireValid && !ssClass && !otherSegClass) |=> !shadowActive); // R3

  AST_NARROW_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (retireValid && !segMode && otherSegClass) |=> !shadowActive); // R6

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !retireValid |=> $stable(shadowActive)); // R11

  AST_ACK_AT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    ackValid |-> $past(retireValid)); // R10

  AST_INTR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ackValid && !ackNmi) |-> $past(intEnable)); // R8

endmodule

// File: tb/irq_shadow_unit_tb.sv
`timescale 1ns/1ps
module irq_shadow_unit_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retireValid = 1'b0;
  logic [2:0] retireClass = 3'd0;
  logic segMode = 1'b0;
  logic intEnable = 1'b0;
  logic intrReq = 1'b0;
  logic nmiReq = 1'b0;
  logic ackValid, ackNmi, shadowActive;

  always #2 clk = ~clk;

  irq_shadow_unit dut_i (
    .clk(clk), .rst_n(rst_n), .retireValid(retireValid), .retireClass(retireClass),
    .segMode(segMode), .intEnable(intEnable), .intrReq(intrReq), .nmiReq(nmiReq),
    .ackValid(ackValid), .ackNmi(ackNmi), .shadowActive(shadowActive)
  );

  typedef struct {
    bit ack;
    bit nmi;
    bit sh;
    string req;
  } exp_t;

  exp_t expQ[$];
  int testCnt = 0;
  int failCnt = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;
  bit expShadow = 1'b0;

  task automatic check(input bit ok, input string req, input string act, input string exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // driver: called at a falling edge
  task automatic doRetire(input logic [2:0] cls, input bit eAck, input bit eNmi,
                          input bit eSh, input string req);
    exp_t e;
    e.ack = eAck; e.nmi = eNmi; e.sh = eSh; e.req = req;
    expQ.push_back(e);
    retireValid = 1'b1;
    retireClass = cls;
    @(negedge clk);
    retireValid = 1'b0;
    retireClass = 3'd0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseNmi();
    nmiReq = 1'b1;
    @(negedge clk);
    nmiReq = 1'b0;
  endtask

  // monitor: pops one expected item per retire strobe
  always begin
    bit hit;
    @(posedge clk);
    hit = monOn && retireValid;
    @(negedge clk);
    if (hit) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "retire with no expectation", "queued item");
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(ackValid === e.ack && (!e.ack || ackNmi === e.nmi) && shadowActive === e.sh,
              e.req,
              $sformatf("ack=%b nmi=%b sh=%b", ackValid, ackNmi, shadowActive),
              $sformatf("ack=%b nmi=%b sh=%b", e.ack, e.nmi, e.sh));
        expShadow = e.sh;
      end
    end else if (monOn) begin
      check(ackValid === 1'b0 && shadowActive === expShadow, "R10 R11",
            $sformatf("ack=%b sh=%b", ackValid, shadowActive),
            $sformatf("ack=0 sh=%b", expShadow));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    idle(3);
    check(ackValid === 1'b0 && shadowActive === 1'b0, "R1",
          $sformatf("ack=%b sh=%b", ackValid, shadowActive), "ack=0 sh=0");
    rst_n = 1'b1;
    idle(2);
    check(ackValid === 1'b0 && shadowActive === 1'b0, "R1",
          $sformatf("ack=%b sh=%b", ackValid, shadowActive), "ack=0 sh=0");
    monOn = 1'b1;

    // narrow mode, basic masking
    segMode = 1'b0; intEnable = 1'b1;
    doRetire(3'd0, 0, 0, 0, "R10 plain no request");
    intrReq = 1'b1;
    doRetire(3'd0, 1, 0, 0, "R8 maskable taken");
    intEnable = 1'b0;
    doRetire(3'd5, 0, 0, 0, "R8 maskable masked");
    intEnable = 1'b1;

    // SS load shadows a held maskable request
    doRetire(3'd1, 0, 0, 1, "R2 move into SS");
    idle(2);
    doRetire(3'd0, 1, 0, 0, "R3 R9 maskable after shadow");
    intrReq = 1'b0;

    // NMI latched before pop into SS, line drops during shadow
    pulseNmi();
    doRetire(3'd2, 0, 0, 1, "R5 NMI blocked by pop into SS");
    idle(3);
    doRetire(3'd6, 1, 1, 0, "R5 R9 latched NMI after shadow");

    // re-arm
    intrReq = 1'b1;
    doRetire(3'd1, 0, 0, 1, "R2 arm");
    doRetire(3'd2, 0, 0, 1, "R4 re-arm");
    doRetire(3'd0, 1, 0, 0, "R3 clears after re-arm");
    intrReq = 1'b0;
    idle(1);

    // narrow mode: other segment loads are ordinary
    intrReq = 1'b1;
    doRetire(3'd3, 1, 0, 0, "R6 narrow move seg");
    doRetire(3'd4, 1, 0, 0, "R6 narrow pop seg");

    // broad mode
    segMode = 1'b1;
    doRetire(3'd3, 0, 0, 1, "R6 broad move seg");
    doRetire(3'd0, 1, 0, 0, "R3 broad clear");
    doRetire(3'd4, 0, 0, 1, "R6 broad pop seg");
    doRetire(3'd7, 1, 0, 0, "R3 broad clear halt");
    doRetire(3'd1, 0, 0, 1, "R6 broad SS");
    doRetire(3'd0, 1, 0, 0, "R3 broad SS clear");

    // priority
    pulseNmi();
    doRetire(3'd0, 1, 1, 0, "R7 NMI first");
    doRetire(3'd0, 1, 0, 0, "R7 maskable next");
    intrReq = 1'b0;

    // NMI ignores the enable flag
    intEnable = 1'b0;
    pulseNmi();
    doRetire(3'd0, 1, 1, 0, "R8 NMI unmasked");
    doRetire(3'd0, 0, 0, 0, "R9 NMI consumed once");
    idle(2);

    monOn = 1'b0;
    check(expQ.size() == 0, "R10", $sformatf("%0d left", expQ.size()), "0 left");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule